// File: doc/BRIEF.md
# Three-Wire Serial Clock-Calendar Access Port

This block lets a host reach a calendar counter over four wires: a chip-enable, a direction select, a serial clock and one shared data line. A fast system clock samples all four host wires through a two-stage synchronizer, and edge detectors find the chip-enable and serial-clock transitions. The level of the direction wire when chip-enable rises fixes the type of access until chip-enable falls again.

In a read, the block copies the counter into a shift register on the chip-enable rise and puts the first bit on the line at once. Each serial-clock fall then moves the next bit onto the line. In a write, the block samples the data line on each serial-clock rise. On the chip-enable fall it hands the last frame's worth of bits to the counter with a one-cycle load strobe. While a write is open it holds a write-active level that freezes the counter. A parameter chooses between the full-calendar frame and the time-only frame. The tri-state pad sits outside the block, driven by a data output and an output-enable.

The load strobe is a valid with no ready. The counter must accept the word in the cycle the strobe is high, and the word stays on the load fields until the next write. The host side has no back-pressure either, because the host sets the pace of the serial clock. Each host edge must last at least three system clocks.

Top module: `rtc_serial_port`

## Requirements
- R1: The direction level when chip-enable rises selects the access: low gives a read with `sdata_oe` high, high gives a write with `wr_active` high and `sdata_oe` low.
- R2: `sdata_oe` is low no later than three system clocks after chip-enable goes low, and stays low while chip-enable stays low. `sdata_o` is 0 whenever `sdata_oe` is low.
- R3: On chip-enable rise in a read, the counter fields are captured, and bit 0 of the frame is on `sdata_o` before any serial clock. Later counter changes do not alter the frame being read.
- R4: In a read, each serial-clock fall moves the next frame bit onto `sdata_o`.
- R5: With FULL_CAL=1 the read frame is 52 bits, sent in this order: year[7:0] (frame bits 0-7), month (8-15), date (16-23), day-of-week[3:0] (24-27), hour (28-35), minute (36-43), second (44-51). Each field is sent LSB first.
- R6: With FULL_CAL=0 the read frame is 28 bits: day-of-week (bits 0-3), hour (4-11), minute (12-19), second (20-27).
- R7: Bits clocked out after the frame length read as 0.
- R8: In a write, the data line is sampled on each serial-clock rise. With FULL_CAL=1, a 44-bit stream of year, month, date, day-of-week, hour, minute (each field LSB first) appears on the load fields.
- R9: If more bits are written than the frame length, only the last ones are kept and the earliest are discarded.
- R10: `ld_valid` is high for exactly one system clock after chip-enable falls in a write. `wr_active` is high from the chip-enable rise until the cycle of the strobe.
- R11: Serial-clock edges while chip-enable is low cause no shift and no load.
- R12: A change of the direction wire while chip-enable is high does not change the access type.
- R13: With FULL_CAL=0 a write keeps the last 20 bits as day-of-week, hour, minute. `ld_year`, `ld_month` and `ld_date` are driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Host chip-enable (asynchronous) |
| dir_i | input | 1 | Host direction: 0 read, 1 write |
| sclk_i | input | 1 | Host serial clock |
| sdata_i | input | 1 | Data line as seen from the pad |
| sdata_o | output | 1 | Data to drive on the pad |
| sdata_oe | output | 1 | Pad output-enable |
| cur_year | input | 8 | Counter year, BCD |
| cur_month | input | 8 | Counter month, BCD |
| cur_date | input | 8 | Counter date, BCD |
| cur_dow | input | 4 | Counter day of week |
| cur_hour | input | 8 | Counter hour, BCD |
| cur_min | input | 8 | Counter minute, BCD |
| cur_sec | input | 8 | Counter second, BCD |
| wr_active | output | 1 | Write open; counter frozen |
| ld_valid | output | 1 | One-cycle load strobe |
| ld_year | output | 8 | Written year |
| ld_month | output | 8 | Written month |
| ld_date | output | 8 | Written date |
| ld_dow | output | 4 | Written day of week |
| ld_hour | output | 8 | Written hour |
| ld_min | output | 8 | Written minute |

## Verification
The bench changes the counter right after the read snapshot. A design that copies the counter late, or copies it again on the first clock, would then send the new value instead of the captured one. It writes a stream longer than the frame, so a design that kept the first bits rather than the last would load garbage. It toggles the direction wire in the middle of both kinds of access, so a design that followed the live level would start or stop driving the line part-way through. It also toggles the serial clock with chip-enable low, so a design that does not gate those edges would shift or load spuriously. It runs the full-calendar and time-only variants side by side on the same stream, so a misplaced field or a wrong frame length shows up as a bit mismatch.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  typedef enum logic [1:0] {ACC_IDLE, ACC_READ, ACC_WRITE} acc_mode_e;

  localparam int FIELD_W = 8;
  localparam int DOW_W   = 4;

  // Read frame: every field, or only day-of-week and time of day.
  function automatic int rd_bits(input bit full);
    return full ? (6 * FIELD_W + DOW_W) : (3 * FIELD_W + DOW_W);
  endfunction

  // Write frame: like the read frame but without seconds.
  function automatic int wr_bits(input bit full);
    return full ? (5 * FIELD_W + DOW_W) : (2 * FIELD_W + DOW_W);
  endfunction
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stage_q[s] <= stage_q[s-1];
      stage_q[0] <= d_i;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rtc_edge.sv
module rtc_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/rtc_frame_codec.sv
module rtc_frame_codec
  import rtc_port_pkg::*;
#(
  parameter bit FULL_CAL = 1'b1,
  parameter int RD_W     = rd_bits(FULL_CAL),
  parameter int WR_W     = wr_bits(FULL_CAL)
) (
  input  logic [7:0]      cur_year,
  input  logic [7:0]      cur_month,
  input  logic [7:0]      cur_date,
  input  logic [3:0]      cur_dow,
  input  logic [7:0]      cur_hour,
  input  logic [7:0]      cur_min,
  input  logic [7:0]      cur_sec,
  output logic [RD_W-1:0] rd_frame_o,
  input  logic [WR_W-1:0] wr_frame_i,
  output logic [7:0]      ld_year,
  output logic [7:0]      ld_month,
  output logic [7:0]      ld_date,
  output logic [3:0]      ld_dow,
  output logic [7:0]      ld_hour,
  output logic [7:0]      ld_min
);
  // Frame bit 0 leaves first, so the first field sits in the low bits.
  if (FULL_CAL) begin : g_full
    assign rd_frame_o = {cur_sec, cur_min, cur_hour, cur_dow,
                         cur_date, cur_month, cur_year};
    assign ld_year  = wr_frame_i[7:0];
    assign ld_month = wr_frame_i[15:8];
    assign ld_date  = wr_frame_i[23:16];
    assign ld_dow   = wr_frame_i[27:24];
    assign ld_hour  = wr_frame_i[35:28];
    assign ld_min   = wr_frame_i[43:36];
  end else begin : g_time
    logic unused_cal;
    assign unused_cal = ^{cur_year, cur_month, cur_date};
    assign rd_frame_o = {cur_sec, cur_min, cur_hour, cur_dow};
    assign ld_year  = '0;
    assign ld_month = '0;
    assign ld_date  = '0;
    assign ld_dow   = wr_frame_i[3:0];
    assign ld_hour  = wr_frame_i[11:4];
    assign ld_min   = wr_frame_i[19:12];
  end
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_port_pkg::*;
#(
  parameter bit FULL_CAL    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_i,
  input  logic       dir_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  output logic       sdata_o,
  output logic       sdata_oe,
  input  logic [7:0] cur_year,
  input  logic [7:0] cur_month,
  input  logic [7:0] cur_date,
  input  logic [3:0] cur_dow,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_sec,
  output logic       wr_active,
  output logic       ld_valid,
  output logic [7:0] ld_year,
  output logic [7:0] ld_month,
  output logic [7:0] ld_date,
  output logic [3:0] ld_dow,
  output logic [7:0] ld_hour,
  output logic [7:0] ld_min
);
  localparam int RD_W = rd_bits(FULL_CAL);
  localparam int WR_W = wr_bits(FULL_CAL);
  localparam int HOST_W = 4;
  localparam int I_CE = 0, I_DIR = 1, I_SCLK = 2, I_DAT = 3;

  logic [HOST_W-1:0] host_raw, host_s;
  logic [1:0]        rise_v, fall_v;
  logic              ce_rise, ce_fall, sclk_rise, sclk_fall;

  acc_mode_e         mode_q;
  logic [RD_W-1:0]   rd_frame, rd_sr;
  logic [WR_W-1:0]   wr_sr, ld_word;
  logic              ld_q;

  assign host_raw = {sdata_i, sclk_i, dir_i, ce_i};

  rtc_sync #(.WIDTH(HOST_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(host_raw), .q_o(host_s)
  );

  rtc_edge #(.WIDTH(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({host_s[I_SCLK], host_s[I_CE]}),
    .rise_o(rise_v), .fall_o(fall_v)
  );

  assign ce_rise   = rise_v[0];
  assign ce_fall   = fall_v[0];
  assign sclk_rise = rise_v[1];
  assign sclk_fall = fall_v[1];

  rtc_frame_codec #(.FULL_CAL(FULL_CAL), .RD_W(RD_W), .WR_W(WR_W)) u_codec (
    .cur_year(cur_year), .cur_month(cur_month), .cur_date(cur_date),
    .cur_dow(cur_dow), .cur_hour(cur_hour), .cur_min(cur_min),
    .cur_sec(cur_sec), .rd_frame_o(rd_frame), .wr_frame_i(ld_word),
    .ld_year(ld_year), .ld_month(ld_month), .ld_date(ld_date),
    .ld_dow(ld_dow), .ld_hour(ld_hour), .ld_min(ld_min)
  );

  // The access type is latched once per chip-enable window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ACC_IDLE;
      rd_sr   <= '0;
      wr_sr   <= '0;
      ld_word <= '0;
      ld_q    <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      if (ce_rise) begin
        mode_q <= host_s[I_DIR] ? ACC_WRITE : ACC_READ;
        wr_sr  <= '0;
        if (!host_s[I_DIR]) rd_sr <= rd_frame;
      end else if (ce_fall) begin
        if (mode_q == ACC_WRITE) begin
          ld_word <= wr_sr;
          ld_q    <= 1'b1;
        end
        mode_q <= ACC_IDLE;
      end else if (mode_q == ACC_READ && sclk_fall) begin
        rd_sr <= {1'b0, rd_sr[RD_W-1:1]};
      end else if (mode_q == ACC_WRITE && sclk_rise) begin
        // New bits enter at the top; the oldest bit drops out at the bottom.
        wr_sr <= {host_s[I_DAT], wr_sr[WR_W-1:1]};
      end
    end
  end

  assign sdata_oe  = (mode_q == ACC_READ) && host_s[I_CE];
  assign sdata_o   = sdata_oe & rd_sr[0];
  assign wr_active = (mode_q == ACC_WRITE);
  assign ld_valid  = ld_q;
endmodule

// File: rtl/rtc_serial_port_chk.sv
module rtc_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_i,
  input logic sdata_o,
  input logic sdata_oe,
  input logic wr_active,
  input logic ld_valid
);
  assert_oe_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ce_i, 1) && !$past(ce_i, 2) && !$past(ce_i, 3)) |-> !sdata_oe);

  assert_line_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_o);

  assert_dir_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdata_oe && wr_active));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);

  assert_strobe_ends_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (!wr_active && $past(wr_active)));
endmodule

bind rtc_serial_port rtc_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sdata_o(sdata_o),
  .sdata_oe(sdata_oe), .wr_active(wr_active), .ld_valid(ld_valid)
);

// File: tb/sim_rtc_serial_port.sv
module sim_rtc_serial_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ce, dir, sclk, sdi;
  logic [7:0] yr, mo, dt, hr, mi, se;
  logic [3:0] dw;

  logic       a_sdo, a_oe, a_wa, a_ld, b_sdo, b_oe, b_wa, b_ld;
  logic [7:0] a_yr, a_mo, a_dt, a_hr, a_mi, b_yr, b_mo, b_dt, b_hr, b_mi;
  logic [3:0] a_dw, b_dw;

  int n_tests = 0, n_fail = 0;
  int ld_cnt_a = 0, ld_cnt_b = 0;

  rtc_serial_port #(.FULL_CAL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .dir_i(dir), .sclk_i(sclk), .sdata_i(sdi),
    .sdata_o(a_sdo), .sdata_oe(a_oe), .cur_year(yr), .cur_month(mo), .cur_date(dt),
    .cur_dow(dw), .cur_hour(hr), .cur_min(mi), .cur_sec(se), .wr_active(a_wa),
    .ld_valid(a_ld), .ld_year(a_yr), .ld_month(a_mo), .ld_date(a_dt), .ld_dow(a_dw),
    .ld_hour(a_hr), .ld_min(a_mi));

  rtc_serial_port #(.FULL_CAL(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .dir_i(dir), .sclk_i(sclk), .sdata_i(sdi),
    .sdata_o(b_sdo), .sdata_oe(b_oe), .cur_year(yr), .cur_month(mo), .cur_date(dt),
    .cur_dow(dw), .cur_hour(hr), .cur_min(mi), .cur_sec(se), .wr_active(b_wa),
    .ld_valid(b_ld), .ld_year(b_yr), .ld_month(b_mo), .ld_date(b_dt), .ld_dow(b_dw),
    .ld_hour(b_hr), .ld_min(b_mi));

  always @(posedge clk) begin
    if (a_ld) ld_cnt_a++;
    if (b_ld) ld_cnt_b++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One read access of 56 serial bits; scramble changes the counter after the snapshot,
  // flip toggles the direction wire part-way through.
  task automatic read_frame(input bit scramble, input bit flip,
                            output logic [55:0] got_a, output logic [55:0] got_b,
                            output bit oe_ok, output bit wa_seen);
    oe_ok = 1'b1; wa_seen = 1'b0;
    dir = 1'b0; wait_clk(4);
    ce = 1'b1; wait_clk(8);
    if (scramble) begin
      yr = 8'h00; mo = 8'h00; dt = 8'h00; dw = 4'h0; hr = 8'h00; mi = 8'h00; se = 8'h00;
    end
    for (int i = 0; i < 56; i++) begin
      got_a[i] = a_sdo; got_b[i] = b_sdo;
      if (!a_oe || !b_oe) oe_ok = 1'b0;
      if (a_wa || b_wa) wa_seen = 1'b1;
      if (flip && i == 4) dir = 1'b1;
      sclk = 1'b1; wait_clk(8);
      sclk = 1'b0; wait_clk(8);
    end
    ce = 1'b0; wait_clk(8);
    dir = 1'b0;
  endtask

  // One write access of n bits, bit 0 first.
  task automatic write_bits(input logic [63:0] bits, input int n, input bit flip,
                            output bit wa_ok, output bit oe_seen);
    wa_ok = 1'b1; oe_seen = 1'b0;
    dir = 1'b1; wait_clk(4);
    ce = 1'b1; wait_clk(8);
    if (flip) dir = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdi = bits[i]; wait_clk(4);
      if (!a_wa || !b_wa) wa_ok = 1'b0;
      if (a_oe || b_oe) oe_seen = 1'b1;
      sclk = 1'b1; wait_clk(8);
      sclk = 1'b0; wait_clk(4);
    end
    ce = 1'b0; wait_clk(16);
    dir = 1'b0; sdi = 1'b0;
  endtask

  function automatic logic [55:0] full_frame();
    return 56'({se, mi, hr, dw, dt, mo, yr});
  endfunction
  function automatic logic [55:0] time_frame();
    return 56'({se, mi, hr, dw});
  endfunction

  task automatic t_reset();
    chk("R2 reset oe", {62'd0, a_oe, b_oe}, 64'd0);
    chk("R10 reset wr_active/ld_valid", {60'd0, a_wa, b_wa, a_ld, b_ld}, 64'd0);
  endtask

  task automatic t_read(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d,
                        input logic [3:0] w, input logic [7:0] h, input logic [7:0] n,
                        input logic [7:0] s, input bit scramble);
    logic [55:0] ga, gb, ea, eb;
    bit oe_ok, wa_seen;
    int la, lb;
    yr = y; mo = m; dt = d; dw = w; hr = h; mi = n; se = s;
    ea = full_frame(); eb = time_frame();
    la = ld_cnt_a; lb = ld_cnt_b;
    read_frame(scramble, 1'b0, ga, gb, oe_ok, wa_seen);
    chk("R5/R3/R4/R7 full read frame", 64'(ga), 64'(ea));
    chk("R6/R7 time-only read frame", 64'(gb), 64'(eb));
    chk("R1 read drives line", 64'(oe_ok), 64'd1);
    chk("R1 read not write-active", 64'(wa_seen), 64'd0);
    chk("R2 oe off after ce low", {62'd0, a_oe, b_oe}, 64'd0);
    chk("R1 read gives no load", 64'((ld_cnt_a - la) + (ld_cnt_b - lb)), 64'd0);
  endtask

  task automatic t_write(input logic [43:0] w, input int extra, input logic [7:0] junk,
                         input bit flip, input string tag);
    logic [63:0] bits;
    bit wa_ok, oe_seen;
    int la, lb;
    bits = (extra == 0) ? 64'(w) : {12'd0, w, junk};
    la = ld_cnt_a; lb = ld_cnt_b;
    write_bits(bits, 44 + extra, flip, wa_ok, oe_seen);
    chk({tag, " R10 wr_active during write"}, 64'(wa_ok), 64'd1);
    chk({tag, " R1/R12 write never drives"}, 64'(oe_seen), 64'd0);
    chk({tag, " R10 one strobe each"}, {32'(ld_cnt_a - la), 32'(ld_cnt_b - lb)}, {32'd1, 32'd1});
    chk({tag, " R10 wr_active cleared"}, {62'd0, a_wa, b_wa}, 64'd0);
    chk({tag, " R8/R9 full load fields"}, {20'd0, a_mi, a_hr, a_dw, a_dt, a_mo, a_yr},
        {20'd0, w});
    chk({tag, " R13/R9 time-only load fields"}, {20'd0, b_mi, b_hr, b_dw, b_dt, b_mo, b_yr},
        {20'd0, w[43:24], 24'd0});
  endtask

  task automatic t_idle_sclk();
    int la, lb;
    logic [7:0] keep_min;
    keep_min = a_mi;
    la = ld_cnt_a; lb = ld_cnt_b;
    ce = 1'b0; dir = 1'b1; sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sclk = 1'b1; wait_clk(8);
      if (a_oe || b_oe) chk("R11 oe while idle", 64'd1, 64'd0);
      sclk = 1'b0; wait_clk(8);
    end
    dir = 1'b0; sdi = 1'b0;
    chk("R11 no load from idle clocks", 64'((ld_cnt_a - la) + (ld_cnt_b - lb)), 64'd0);
    chk("R11 load fields held", 64'(a_mi), 64'(keep_min));
  endtask

  task automatic t_read_dir_flip();
    logic [55:0] ga, gb;
    bit oe_ok, wa_seen;
    int la;
    yr = 8'h31; mo = 8'h07; dt = 8'h19; dw = 4'h2; hr = 8'h08; mi = 8'h45; se = 8'h12;
    la = ld_cnt_a;
    read_frame(1'b0, 1'b1, ga, gb, oe_ok, wa_seen);
    chk("R12 read stays read after dir flip", {62'd0, oe_ok, wa_seen}, 64'd2);
    chk("R12 frame intact after dir flip", 64'(ga), 64'(full_frame()));
    chk("R12 no load from flipped read", 64'(ld_cnt_a - la), 64'd0);
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; dir = 1'b0; sclk = 1'b0; sdi = 1'b0;
    yr = 8'h00; mo = 8'h00; dt = 8'h00; dw = 4'h0; hr = 8'h00; mi = 8'h00; se = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_read(8'h24, 8'h11, 8'h28, 4'h5, 8'h23, 8'h59, 8'h58, 1'b1);
    t_read(8'h99, 8'h12, 8'h31, 4'h7, 8'h12, 8'h34, 8'h56, 1'b0);
    t_write({8'h30, 8'h17, 4'h3, 8'h29, 8'h02, 8'h96}, 0, 8'h00, 1'b0, "exact");
    t_write({8'h05, 8'h21, 4'h6, 8'h01, 8'h10, 8'h43}, 8, 8'hA5, 1'b0, "overlong");
    t_write({8'h11, 8'h09, 4'h1, 8'h15, 8'h04, 8'h77}, 0, 8'h00, 1'b1, "dirflip R12");
    t_idle_sclk();
    t_read_dir_flip();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule